// File: doc/BRIEF.md
# PHY Control-Register Bus Sequencer

This block performs single read or write accesses to the internal control registers of a PHY. The PHY is reached over a narrow handshake bus: one 20-bit control word driven towards the PHY and one 17-bit status word returned from it. Each step of an access is a full four-phase exchange. The sequencer raises a strobe and waits for the acknowledge to go high. It then changes the strobe and waits for the acknowledge to go low again.

A host presents a request with a direction, a 16-bit register address and 16-bit write data. When the access has finished, the host receives a one-cycle `done` pulse, an `error` flag and, for reads, the returned data. Every access starts with an address-capture exchange. A write adds a data-capture exchange before the write strobe. Each acknowledge wait is bounded: an acknowledge that is missing or stuck ends the access with an error, so the block never hangs.

Top module: `phy_cr_sequencer`

## Requirements
- R1: The control word carries the data field in bits 15:0, capture-address in bit 16, capture-data in bit 17, write in bit 18 and read in bit 19. The status word carries read data in bits 15:0 and acknowledge in bit 16. After reset the control word is all zero, `done` and `error` are low and `rdata` is zero.
- R2: In the cycle after a request is accepted, the control word holds the address with capture-address set. Once acknowledge is seen high, capture-address drops while the address stays on the data field, and the block waits for acknowledge low.
- R3: A read raises the read strobe alone with a zero data field and waits for acknowledge high. At that sample it captures status bits 15:0 into `rdata`. It then clears the control word and waits for acknowledge low. `rdata` changes at no other time.
- R4: A write drives the write data with capture-data set and waits for acknowledge high. It then keeps the data, drops capture-data and waits for acknowledge low. Next it raises the write strobe alone and waits for acknowledge high, puts the data back on the field with the strobe dropped, waits for acknowledge low, and finally clears the control word.
- R5: The acknowledge is sampled once per clock. A wait succeeds if the expected level is seen on any of its first 100 samples. A wait whose level first appears on the 100th sample still succeeds.
- R6: If 100 consecutive samples of a wait miss the expected level, the access aborts. The control word returns to zero, and `done` and `error` are both high for one cycle.
- R7: A request is accepted only while the block is idle. A request presented during an access has no effect on that access or on the PHY.
- R8: `done` is a single-cycle pulse, with `error` low after a successful access. While `done` is high the control word is zero and a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Data for a write |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with `done`; acknowledge timeout |
| rdata | output | 16 | Data returned by the last read |
| phy_ctl | output | 20 | Control word towards the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The assertions assume that the acknowledge bit is synchronous to `clk` and is stable around each rising edge. They also assume that reset is held for at least one edge before any request. The bench model of the PHY changes acknowledge and status data only on the falling edge, and it derives acknowledge from the strobes it sees after a chosen number of cycles. Timeouts are produced deliberately by pinning acknowledge low or high. Between tests the bench allows the pinned acknowledge to settle before it presents the next request.

// File: rtl/phy_cr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the PHY control-register bus sequencer.
// Assumes the strobe bits sit directly above the data field of the
// control word, in the order given by the offsets below.
package phy_cr_pkg;

    // Number of strobe bits above the data field
    localparam int STROBE_N = 4;
    // Strobe offsets above the data field
    localparam int OFS_CAPA = 0;
    localparam int OFS_CAPD = 1;
    localparam int OFS_WR   = 2;
    localparam int OFS_RD   = 3;

    // Steps of one access; *_HI waits for ack high, *_LO for ack low
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR_HI = 3'd1,
        ST_ADDR_LO = 3'd2,
        ST_DATA_HI = 3'd3,
        ST_DATA_LO = 3'd4,
        ST_STRB_HI = 3'd5,
        ST_STRB_LO = 3'd6
    } step_e;

    // Acknowledge level a step waits for
    function automatic logic want_high(input step_e s);
        return (s == ST_ADDR_HI) || (s == ST_DATA_HI) || (s == ST_STRB_HI);
    endfunction

    // Step that follows s once its wait is satisfied
    function automatic step_e step_after(input step_e s, input logic wr_txn);
        case (s)
            ST_ADDR_HI: return ST_ADDR_LO;
            ST_ADDR_LO: return wr_txn ? ST_DATA_HI : ST_STRB_HI;
            ST_DATA_HI: return ST_DATA_LO;
            ST_DATA_LO: return ST_STRB_HI;
            ST_STRB_HI: return ST_STRB_LO;
            default:    return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/phy_cr_poll.sv
`timescale 1ns/1ps
// Bounded poll counter. It counts acknowledge samples that missed the
// expected level within the current wait, and it flags the last sample
// allowed. Assumes one sample per clock and that clr is raised on every
// step change.
module phy_cr_poll #(
    parameter int POLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic miss,
    output logic last
);
    localparam int CNT_W = (POLLS > 1) ? $clog2(POLLS) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(POLLS - 1);

    logic [CNT_W-1:0] cnt;

    // Count missed samples; saturate at the last allowed one
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (miss && (cnt != CNT_TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CNT_TOP);

    // R5
    poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_TOP);

    // R5
    poll_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/phy_cr_seq.sv
`timescale 1ns/1ps
// Step sequencer. It accepts a request when idle, walks the address,
// data and strobe steps, captures read data and reports completion or
// timeout. Assumes ack and stat_data are synchronous to clk.
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] stat_data,
    input  logic              poll_last,
    output logic              poll_clr,
    output logic              poll_miss,
    output step_e             step,
    output logic              wr_txn,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] rdata
);
    logic  busy;
    logic  hit;
    step_e nxt;

    // Decode whether the current wait is satisfied this cycle
    always_comb begin
        busy = (step != ST_IDLE);
        hit  = busy && (ack == want_high(step));
        nxt  = step_after(step, wr_txn);
    end

    assign poll_clr  = !busy || hit;
    assign poll_miss = busy && !hit;

    // Step register, request latch, completion flags and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= ST_IDLE;
            wr_txn  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
            rdata   <= '0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            if (!busy) begin
                if (req_valid) begin
                    wr_txn  <= req_write;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    step    <= ST_ADDR_HI;
                end
            end else if (hit) begin
                if ((step == ST_STRB_HI) && !wr_txn) begin
                    rdata <= stat_data;
                end
                step <= nxt;
                if (nxt == ST_IDLE) begin
                    done <= 1'b1;
                end
            end else if (poll_last) begin
                step  <= ST_IDLE;
                done  <= 1'b1;
                error <= 1'b1;
            end
        end
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_txn)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (done && (step == ST_IDLE)));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((step != ST_STRB_HI) || wr_txn) |=> $stable(rdata));

endmodule

// File: rtl/phy_cr_drv.sv
`timescale 1ns/1ps
// Control-word decoder. It maps the current step and the latched request
// onto the data field and the four strobes. Assumes its inputs come from
// registers, so the word changes only just after a clock edge.
module phy_cr_drv
    import phy_cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  step_e                      step,
    input  logic                       wr_txn,
    input  logic [DATA_W-1:0]          addr_q,
    input  logic [DATA_W-1:0]          wdata_q,
    output logic [DATA_W+STROBE_N-1:0] ctl
);
    // Build the word for each step; idle and read cleanup drive zero
    always_comb begin
        ctl = '0;
        case (step)
            ST_ADDR_HI: begin
                ctl[DATA_W-1:0]      = addr_q;
                ctl[DATA_W+OFS_CAPA] = 1'b1;
            end
            ST_ADDR_LO: ctl[DATA_W-1:0] = addr_q;
            ST_DATA_HI: begin
                ctl[DATA_W-1:0]      = wdata_q;
                ctl[DATA_W+OFS_CAPD] = 1'b1;
            end
            ST_DATA_LO: ctl[DATA_W-1:0] = wdata_q;
            ST_STRB_HI: begin
                if (wr_txn) ctl[DATA_W+OFS_WR] = 1'b1;
                else        ctl[DATA_W+OFS_RD] = 1'b1;
            end
            ST_STRB_LO: begin
                if (wr_txn) ctl[DATA_W-1:0] = wdata_q;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/phy_cr_sequencer.sv
`timescale 1ns/1ps
// Top of the PHY control-register bus sequencer. It joins the step
// sequencer, the bounded poll counter and the control-word decoder.
// Assumes phy_stat is synchronous to clk and reset is synchronous.
module phy_cr_sequencer
    import phy_cr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int POLLS  = 100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [DATA_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       done,
    output logic                       error,
    output logic [DATA_W-1:0]          rdata,
    output logic [DATA_W+STROBE_N-1:0] phy_ctl,
    input  logic [DATA_W:0]            phy_stat
);
    localparam int CTL_W = DATA_W + STROBE_N;

    step_e             step;
    logic              wr_txn;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              poll_clr;
    logic              poll_miss;
    logic              poll_last;

    phy_cr_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack       (phy_stat[DATA_W]),
        .stat_data (phy_stat[DATA_W-1:0]),
        .poll_last (poll_last),
        .poll_clr  (poll_clr),
        .poll_miss (poll_miss),
        .step      (step),
        .wr_txn    (wr_txn),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .done      (done),
        .error     (error),
        .rdata     (rdata)
    );

    phy_cr_poll #(.POLLS(POLLS)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .miss  (poll_miss),
        .last  (poll_last)
    );

    phy_cr_drv #(.DATA_W(DATA_W)) u_drv (
        .step    (step),
        .wr_txn  (wr_txn),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ctl     (phy_ctl)
    );

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctl[CTL_W-1:DATA_W]));

    // R8
    done_idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phy_ctl == '0));

    // R2
    capa_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_ctl[DATA_W+OFS_CAPA]) |-> $past(req_valid));

endmodule

// File: tb/phy_cr_sequencer_tb.sv
`timescale 1ns/1ps
module phy_cr_sequencer_tb;
    localparam int POLLS = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [16:0] phy_stat = '0;
    logic        done, error;
    logic [15:0] rdata;
    logic [19:0] phy_ctl;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    phy_cr_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .error(error),
        .rdata(rdata), .phy_ctl(phy_ctl), .phy_stat(phy_stat)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(16'h3000 + i * 37);
    endfunction

    // PHY model: register file, latches and acknowledge with a set latency
    logic [15:0] mem [0:255];
    logic [15:0] alat = '0, dlat = '0;
    logic        ack = 1'b0;
    int          dly = 1;
    int          ack_mode = 0;
    int          wait_n = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    end

    always @(negedge clk) begin
        logic strobe;
        strobe = |phy_ctl[19:16];
        if (phy_ctl[16]) alat = phy_ctl[15:0];
        if (phy_ctl[17]) dlat = phy_ctl[15:0];
        if (phy_ctl[18]) mem[alat[7:0]] = dlat;
        if (ack_mode == 1) ack = 1'b0;
        else if (ack_mode == 2) ack = 1'b1;
        else if (ack != strobe) begin
            wait_n++;
            if (wait_n >= dly) begin ack = strobe; wait_n = 0; end
        end else wait_n = 0;
        phy_stat = {ack, (ack && phy_ctl[19]) ? mem[alat[7:0]] : 16'h5A5A};
    end

    // Reference model: a queue of {capture, level, word} steps per access
    logic [21:0] q[$];
    int          m_cnt = 0;
    logic [19:0] exp_ctl = '0;
    logic        exp_done = 1'b0, exp_err = 1'b0;
    logic [15:0] exp_rdata = '0;

    always @(posedge clk) begin
        exp_done = 1'b0;
        exp_err  = 1'b0;
        if (!rst_n) begin
            q.delete(); m_cnt = 0; exp_rdata = '0;
        end else if (q.size() == 0) begin
            if (req_valid) begin
                m_cnt = 0;
                q.push_back({2'b01, 4'b0001, req_addr});
                q.push_back({2'b00, 4'b0000, req_addr});
                if (req_write) begin
                    q.push_back({2'b01, 4'b0010, req_wdata});
                    q.push_back({2'b00, 4'b0000, req_wdata});
                    q.push_back({2'b01, 4'b0100, 16'h0});
                    q.push_back({2'b00, 4'b0000, req_wdata});
                end else begin
                    q.push_back({2'b11, 4'b1000, 16'h0});
                    q.push_back({2'b00, 4'b0000, 16'h0});
                end
            end
        end else begin
            if (phy_stat[16] == q[0][20]) begin
                if (q[0][21]) exp_rdata = phy_stat[15:0];
                void'(q.pop_front());
                m_cnt = 0;
                if (q.size() == 0) exp_done = 1'b1;
            end else begin
                m_cnt++;
                if (m_cnt == POLLS) begin
                    q.delete(); m_cnt = 0; exp_done = 1'b1; exp_err = 1'b1;
                end
            end
        end
        exp_ctl = (q.size() != 0) ? q[0][19:0] : 20'h0;
    end

    // Per-cycle comparison against the model (covers R2 R3 R4 R6 R8)
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            n_chk++;
            if (phy_ctl !== exp_ctl || done !== exp_done || error !== exp_err ||
                rdata !== exp_rdata) begin
                n_fail++;
                $display("FAIL R2/R3/R4/R6/R8 cycle model: ctl=%h done=%b err=%b rdata=%h expected ctl=%h done=%b err=%b rdata=%h",
                         phy_ctl, done, error, rdata, exp_ctl, exp_done, exp_err, exp_rdata);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit e, output logic [15:0] r, output int cyc);
        cyc = 0;
        e = 1'b0; r = '0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin e = error; r = rdata; cyc = i; return; end
            @(negedge clk);
        end
        n_chk++; n_fail++;
        $display("FAIL R8 done never seen: actual 0 expected 1");
    endtask

    task automatic finish_up();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual hung expected finished");
        finish_up();
    end

    initial begin
        bit e;
        logic [15:0] r;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(phy_ctl == 20'h0, "R1 reset ctl", 32'(phy_ctl), 0);
        chk(!done && !error, "R1 reset done/error", {done, error}, 0);
        chk(rdata == 16'h0, "R1 reset rdata", 32'(rdata), 0);
        cmp_en = 1'b1;

        // R2 address phase word in the cycle after acceptance
        dly = 3;
        issue(1'b0, 16'h0012, 16'h0);
        chk(phy_ctl == 20'h10012, "R2 capture-address word", 32'(phy_ctl), 32'h10012);
        wait_done(e, r, cyc);
        // R3 read returns PHY contents
        chk(!e, "R3 read error flag", 32'(e), 0);
        chk(r == init_val(8'h12), "R3 read data", 32'(r), 32'(init_val(8'h12)));

        // R4 write then read back, several latencies
        dly = 1;
        issue(1'b1, 16'h0040, 16'hBEEF);
        wait_done(e, r, cyc);
        chk(!e, "R4 write error flag", 32'(e), 0);
        @(negedge clk);
        chk(!done, "R8 done single cycle", 32'(done), 0);
        dly = 7;
        issue(1'b0, 16'h0040, 16'h0);
        wait_done(e, r, cyc);
        chk(r == 16'hBEEF, "R4 write readback", 32'(r), 32'hBEEF);
        dly = 2;
        issue(1'b1, 16'h00FF, 16'h1234);
        wait_done(e, r, cyc);
        issue(1'b0, 16'h00FF, 16'h0);
        wait_done(e, r, cyc);
        chk(r == 16'h1234, "R4 write readback 2", 32'(r), 32'h1234);

        // R7 stray requests during a write are ignored
        dly = 4;
        issue(1'b1, 16'h0010, 16'h1111);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020; req_wdata = 16'h2222;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        wait_done(e, r, cyc);
        repeat (3) @(negedge clk);
        chk(!done, "R7 no second access", 32'(done), 0);
        dly = 1;
        issue(1'b0, 16'h0020, 16'h0);
        wait_done(e, r, cyc);
        chk(r == init_val(8'h20), "R7 stray address untouched", 32'(r), 32'(init_val(8'h20)));
        issue(1'b0, 16'h0010, 16'h0);
        wait_done(e, r, cyc);
        chk(r == 16'h1111, "R7 accepted write intact", 32'(r), 32'h1111);

        // R5 acknowledge on the last allowed sample still succeeds
        dly = POLLS;
        issue(1'b1, 16'h0031, 16'hA5A5);
        wait_done(e, r, cyc);
        chk(!e, "R5 ack on sample 100", 32'(e), 0);
        dly = 1;
        issue(1'b0, 16'h0031, 16'h0);
        wait_done(e, r, cyc);
        chk(r == 16'hA5A5, "R5 data after slow write", 32'(r), 32'hA5A5);

        // R5 one sample too late times out
        dly = POLLS + 1;
        issue(1'b0, 16'h0005, 16'h0);
        wait_done(e, r, cyc);
        chk(e, "R5 ack on sample 101 times out", 32'(e), 1);
        dly = 1;
        repeat (POLLS + 5) @(negedge clk);

        // R6 acknowledge stuck low
        ack_mode = 1;
        issue(1'b1, 16'h0006, 16'h7777);
        wait_done(e, r, cyc);
        chk(e, "R6 stuck-low error", 32'(e), 1);
        chk(phy_ctl == 20'h0, "R6 word cleared", 32'(phy_ctl), 0);
        ack_mode = 0;
        repeat (5) @(negedge clk);

        // R6 acknowledge stuck high
        ack_mode = 2;
        repeat (2) @(negedge clk);
        issue(1'b0, 16'h0007, 16'h0);
        wait_done(e, r, cyc);
        chk(e, "R6 stuck-high error", 32'(e), 1);
        ack_mode = 0;
        repeat (5) @(negedge clk);

        // R3 recovery read after timeouts
        issue(1'b0, 16'h0006, 16'h0);
        wait_done(e, r, cyc);
        chk(!e && r == init_val(6), "R3 read after timeout", 32'(r), 32'(init_val(6)));
        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule